// File: doc/BRIEF.md
# Column Command Data Window Generator

This block belongs to the command path of a DDR2 memory controller. Each time the controller accepts a READ or WRITE column command, the block works out when the data bus will carry that burst. It then raises the matching enable for exactly that many clocks. A write enable tells the data path when to drive write data and its byte mask. A read enable tells the capture logic when returning data is due. A beat index says which pair of double-rate beats belongs to the current clock.

The read latency is the programmed CAS latency plus the additive latency used for posted column commands. The write latency is always one clock less than the read latency. A burst of 4 or 8 beats moves two beats per clock, so it fills 2 or 4 clocks. Because the additive latency can be changed from one command to the next, a command issued later can finish earlier than one issued before it. The block keeps every pending command in a delay line. A bus-occupancy map rejects any command whose window would share a clock with a window already scheduled.

Configuration inputs are sampled only on the clock edge that accepts a command. Changing them afterwards does not move a window that is already scheduled.

Top module: `colcmd_window_gen`

## Requirements
- R1: A read accepted on rising edge k raises `rd_en` in the clocks after edges k+RL onward, where RL is the effective additive latency plus the effective CAS latency.
- R2: A write accepted on edge k raises `wr_en` starting in the clock after edge k+RL-1, which is one clock earlier than a read with the same settings.
- R3: `cfg_cl` takes effect as 3, 4, 5 or 6; a value below 3 acts as 3 and a value above 6 acts as 6. `cfg_al` takes effect as 0 to 4; a value above 4 acts as 4.
- R4: `cfg_bl8`=0 selects 4 beats, so the window lasts 2 clocks. `cfg_bl8`=1 selects 8 beats, so the window lasts 4 clocks.
- R5: While a window is open, `beat_idx` holds the even index of the first beat in the current clock: 0,2 for a 4-beat burst and 0,2,4,6 for an 8-beat burst. It is 0 when no window is open.
- R6: In every clock of a write window, `wr_dm` equals the `cmd_dm` value sampled with that write command. Outside write windows it is 0.
- R7: `rd_en` and `wr_en` are never high in the same clock.
- R8: Several accepted commands can be pending at once. Windows that abut follow each other with no idle clock, and `beat_idx` restarts at 0 for each burst.
- R9: If a command's window would share any clock with an already accepted window, the command is dropped and produces no window. `overlap_err` is then high for the one clock after the edge that sampled that command.
- R10: While `rst` is high, all outputs are 0 and every pending command is discarded, so no window appears after reset is released.
- R11: `cfg_cl`, `cfg_al` and `cfg_bl8` matter only on the edge that accepts a command. Changing them later does not alter a window that is already scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A column command is accepted on this edge |
| cmd_is_write | input | 1 | 1 for write, 0 for read |
| cmd_dm | input | DM_BYTES | Byte mask to apply to every beat of the write |
| cfg_cl | input | 3 | Programmed CAS latency |
| cfg_al | input | 3 | Programmed additive latency |
| cfg_bl8 | input | 1 | 1 for 8-beat bursts, 0 for 4-beat bursts |
| wr_en | output | 1 | Write data drive window |
| rd_en | output | 1 | Read data capture window |
| beat_idx | output | 3 | Even index of the first beat in this clock |
| wr_dm | output | DM_BYTES | Byte mask aligned with the write beats |
| overlap_err | output | 1 | A command was dropped because its window collided |

## Verification
Single commands are tried over a spread of CAS and additive latency pairs, both burst lengths and both directions. This separates a correct sum of the two latencies from an off-by-one error, from ignoring the additive part, and from giving writes the same latency as reads. Out-of-range settings show whether clamping works. Multi-command patterns cover several cases:
- back-to-back reads, which must form a seamless window;
- a read followed by a write one clock too early, which must collide and be dropped, and one clock later, which must abut;
- three commands whose issue order differs from their completion order;
- a configuration change after acceptance.

These separate a real occupancy map from a check against the previous command only, and show whether settings are captured per command. A reset in mid-flight shows that pending entries are flushed.

// File: rtl/ddr_win_pkg.sv
package ddr_win_pkg;

    localparam int CFG_W    = 3;
    localparam int MIN_CL   = 3;
    localparam int MAX_CL   = 6;
    localparam int MAX_AL   = 4;
    localparam int MAX_RL   = MAX_CL + MAX_AL;
    localparam int LAT_W    = $clog2(MAX_RL + 1);
    localparam int MAX_SPAN = 4;
    localparam int SPAN_W   = $clog2(MAX_SPAN + 1);
    localparam int CNT_W    = $clog2(MAX_SPAN);
    localparam int BEAT_W   = CNT_W + 1;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    typedef struct packed {
        logic live;
        dir_e dir;
        logic bl8;
    } slot_t;

    function automatic logic [CFG_W-1:0] eff_cl(input logic [CFG_W-1:0] cl);
        if (int'(cl) < MIN_CL)      return CFG_W'(MIN_CL);
        else if (int'(cl) > MAX_CL) return CFG_W'(MAX_CL);
        else                        return cl;
    endfunction

    function automatic logic [CFG_W-1:0] eff_al(input logic [CFG_W-1:0] al);
        if (int'(al) > MAX_AL) return CFG_W'(MAX_AL);
        else                   return al;
    endfunction

    function automatic logic [SPAN_W-1:0] span_clks(input logic bl8);
        return bl8 ? SPAN_W'(MAX_SPAN) : SPAN_W'(MAX_SPAN / 2);
    endfunction

endpackage

// File: rtl/win_latency_calc.sv
module win_latency_calc
    import ddr_win_pkg::*;
(
    input  logic [CFG_W-1:0]  cfg_cl,
    input  logic [CFG_W-1:0]  cfg_al,
    input  dir_e              dir,
    input  logic              bl8,
    output logic [LAT_W-1:0]  lead,
    output logic [SPAN_W-1:0] span
);
    logic [LAT_W-1:0] rd_lat;

    always_comb begin
        rd_lat = LAT_W'(eff_cl(cfg_cl)) + LAT_W'(eff_al(cfg_al));
        lead   = (dir == DIR_WR) ? rd_lat - LAT_W'(1) : rd_lat;
        span   = span_clks(bl8);
    end
endmodule

// File: rtl/win_bus_tracker.sv
module win_bus_tracker
    import ddr_win_pkg::*;
#(
    parameter int OCC_W = MAX_RL + MAX_SPAN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [LAT_W-1:0]  lead,
    input  logic [SPAN_W-1:0] span,
    output logic              accept,
    output logic              clash,
    output logic              busy_now
);
    localparam int CMP_W = LAT_W + 1;

    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] shifted;
    logic [OCC_W-1:0] want;
    logic [CMP_W-1:0] lo;
    logic [CMP_W-1:0] hi;

    assign lo      = {1'b0, lead};
    assign hi      = lo + CMP_W'(span);
    assign shifted = {1'b0, occ_q[OCC_W-1:1]};

    for (genvar j = 0; j < OCC_W; j++) begin : g_want
        localparam logic [CMP_W-1:0] POS = CMP_W'(j);
        assign want[j] = (POS >= lo) && (POS < hi);
    end

    assign clash    = req && |(shifted & want);
    assign accept   = req && !clash;
    assign busy_now = occ_q[0];

    always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else     occ_q <= shifted | (accept ? want : '0);
    end
endmodule

// File: rtl/win_delay_line.sv
module win_delay_line
    import ddr_win_pkg::*;
#(
    parameter int DEPTH    = 12,
    parameter int DM_BYTES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ins,
    input  logic [LAT_W-1:0]    ins_lead,
    input  slot_t               ins_slot,
    input  logic [DM_BYTES-1:0] ins_dm,
    output slot_t               head,
    output logic [DM_BYTES-1:0] head_dm
);
    slot_t [DEPTH-1:0]                slot_q, slot_nxt;
    logic  [DEPTH-1:0][DM_BYTES-1:0]  dm_q, dm_nxt;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_t               up;
        logic [DM_BYTES-1:0] up_dm;
        logic                hit;
        if (i == DEPTH - 1) begin : g_top
            assign up    = '0;
            assign up_dm = '0;
        end else begin : g_mid
            assign up    = slot_q[i+1];
            assign up_dm = dm_q[i+1];
        end
        assign hit         = ins && (int'(ins_lead) == i + 1);
        assign slot_nxt[i] = hit ? ins_slot : up;
        assign dm_nxt[i]   = hit ? ins_dm : up_dm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            dm_q   <= '0;
        end else begin
            slot_q <= slot_nxt;
            dm_q   <= dm_nxt;
        end
    end

    assign head    = slot_q[0];
    assign head_dm = dm_q[0];
endmodule

// File: rtl/win_burst_engine.sv
module win_burst_engine
    import ddr_win_pkg::*;
#(
    parameter int DM_BYTES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_t               head,
    input  logic [DM_BYTES-1:0] head_dm,
    output logic                wr_en,
    output logic                rd_en,
    output logic [BEAT_W-1:0]   beat_idx,
    output logic [DM_BYTES-1:0] wr_dm
);
    logic                active_q;
    dir_e                dir_q;
    logic                bl8_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [DM_BYTES-1:0] dm_q;
    logic [CNT_W-1:0]    last;

    assign last = CNT_W'(span_clks(bl8_q) - SPAN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            dir_q    <= DIR_RD;
            bl8_q    <= 1'b0;
            cnt_q    <= '0;
            dm_q     <= '0;
        end else if (head.live) begin
            active_q <= 1'b1;
            dir_q    <= head.dir;
            bl8_q    <= head.bl8;
            cnt_q    <= '0;
            dm_q     <= head_dm;
        end else if (active_q) begin
            if (cnt_q == last) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign wr_en    = active_q && (dir_q == DIR_WR);
    assign rd_en    = active_q && (dir_q == DIR_RD);
    assign beat_idx = active_q ? {cnt_q, 1'b0} : '0;
    assign wr_dm    = wr_en ? dm_q : '0;
endmodule

// File: rtl/colcmd_window_gen.sv
module colcmd_window_gen
    import ddr_win_pkg::*;
#(
    parameter int DEPTH    = 12,
    parameter int DM_BYTES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic                cmd_is_write,
    input  logic [DM_BYTES-1:0] cmd_dm,
    input  logic [2:0]          cfg_cl,
    input  logic [2:0]          cfg_al,
    input  logic                cfg_bl8,
    output logic                wr_en,
    output logic                rd_en,
    output logic [2:0]          beat_idx,
    output logic [DM_BYTES-1:0] wr_dm,
    output logic                overlap_err
);
    dir_e                cmd_dir;
    logic [LAT_W-1:0]    lead;
    logic [SPAN_W-1:0]   span;
    logic                accept;
    logic                clash;
    logic                bus_busy;
    slot_t               new_slot;
    slot_t               head;
    logic [DM_BYTES-1:0] head_dm;
    logic                err_q;

    assign cmd_dir  = cmd_is_write ? DIR_WR : DIR_RD;
    assign new_slot = '{live: 1'b1, dir: cmd_dir, bl8: cfg_bl8};

    win_latency_calc u_lat (
        .cfg_cl (cfg_cl),
        .cfg_al (cfg_al),
        .dir    (cmd_dir),
        .bl8    (cfg_bl8),
        .lead   (lead),
        .span   (span)
    );

    win_bus_tracker #(.OCC_W(MAX_RL + MAX_SPAN)) u_track (
        .clk      (clk),
        .rst      (rst),
        .req      (cmd_valid),
        .lead     (lead),
        .span     (span),
        .accept   (accept),
        .clash    (clash),
        .busy_now (bus_busy)
    );

    win_delay_line #(.DEPTH(DEPTH), .DM_BYTES(DM_BYTES)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .ins      (accept),
        .ins_lead (lead),
        .ins_slot (new_slot),
        .ins_dm   (cmd_dm),
        .head     (head),
        .head_dm  (head_dm)
    );

    win_burst_engine #(.DM_BYTES(DM_BYTES)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .head     (head),
        .head_dm  (head_dm),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .beat_idx (beat_idx),
        .wr_dm    (wr_dm)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= clash;
    end

    assign overlap_err = err_q;
endmodule

// File: rtl/colcmd_window_gen_chk.sv
module colcmd_window_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       rd_en,
    input logic       wr_en,
    input logic [2:0] beat_idx,
    input logic       overlap_err,
    input logic       bus_busy
);
    a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    // R9: occupancy map and burst engine agree on when the bus is in use
    a_r9_busy_tracks_window: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) == bus_busy);

    a_r9_err_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        overlap_err |-> $past(cmd_valid));

    a_r5_window_opens_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en || wr_en) |-> beat_idx == 3'd0);

    a_r5_beat_steps_by_two: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && beat_idx != 3'd0)
            |-> ($past(rd_en || wr_en) && beat_idx == $past(beat_idx) + 3'd2));

    a_r4_window_ends_on_last_pair: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_en || wr_en) |-> ($past(beat_idx) == 3'd2 || $past(beat_idx) == 3'd6));
endmodule

bind colcmd_window_gen colcmd_window_gen_chk chk_i (.*);

// File: tb/colcmd_window_gen_tb_top.sv
`timescale 1ns/1ps
module colcmd_window_gen_tb_top;

    localparam int NCYC = 24;

    typedef struct packed {
        logic       wr;
        logic [2:0] cl;
        logic [2:0] al;
        logic       bl8;
        logic [1:0] dm;
        logic [3:0] lead;
        logic [2:0] len;
    } vec_t;

    // read lead = eff AL + eff CL, write lead = that minus 1, len = 2 or 4 clocks
    localparam vec_t VECS [8] = '{
        '{1'b0, 3'd3, 3'd0, 1'b0, 2'b00, 4'd3,  3'd2},
        '{1'b1, 3'd3, 3'd0, 1'b0, 2'b01, 4'd2,  3'd2},
        '{1'b0, 3'd6, 3'd4, 1'b1, 2'b00, 4'd10, 3'd4},
        '{1'b1, 3'd6, 3'd4, 1'b1, 2'b10, 4'd9,  3'd4},
        '{1'b0, 3'd5, 3'd2, 1'b1, 2'b00, 4'd7,  3'd4},
        '{1'b1, 3'd4, 3'd1, 1'b0, 2'b11, 4'd4,  3'd2},
        '{1'b0, 3'd1, 3'd0, 1'b0, 2'b00, 4'd3,  3'd2},
        '{1'b1, 3'd7, 3'd7, 1'b1, 2'b01, 4'd9,  3'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_is_write = 1'b0;
    logic [1:0] cmd_dm = '0;
    logic [2:0] cfg_cl = '0;
    logic [2:0] cfg_al = '0;
    logic       cfg_bl8 = 1'b0;
    logic       wr_en, rd_en, overlap_err;
    logic [2:0] beat_idx;
    logic [1:0] wr_dm;

    int n_chk = 0;
    int n_err = 0;

    logic       sc_v [NCYC];
    logic       sc_w [NCYC];
    logic [2:0] sc_cl [NCYC];
    logic [2:0] sc_al [NCYC];
    logic       sc_b [NCYC];
    logic [1:0] sc_dm [NCYC];
    logic       ex_rd [NCYC];
    logic       ex_wr [NCYC];
    logic       ex_err [NCYC];
    logic [2:0] ex_beat [NCYC];
    logic [1:0] ex_dm [NCYC];

    always #2 clk = ~clk;

    colcmd_window_gen #(.DEPTH(12), .DM_BYTES(2)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_is_write (cmd_is_write),
        .cmd_dm       (cmd_dm),
        .cfg_cl       (cfg_cl),
        .cfg_al       (cfg_al),
        .cfg_bl8      (cfg_bl8),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .beat_idx     (beat_idx),
        .wr_dm        (wr_dm),
        .overlap_err  (overlap_err)
    );

    task automatic chk(input string req, input string what, input int cyc,
                       input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int c = 0; c < NCYC; c++) begin
            sc_v[c] = 0; sc_w[c] = 0; sc_cl[c] = 0; sc_al[c] = 0; sc_b[c] = 0; sc_dm[c] = 0;
            ex_rd[c] = 0; ex_wr[c] = 0; ex_err[c] = 0; ex_beat[c] = 0; ex_dm[c] = 0;
        end
    endtask

    task automatic put_cmd(input int c, input logic v, input logic w, input logic [2:0] cl,
                           input logic [2:0] al, input logic b, input logic [1:0] dm);
        sc_v[c] = v; sc_w[c] = w; sc_cl[c] = cl; sc_al[c] = al; sc_b[c] = b; sc_dm[c] = dm;
    endtask

    task automatic add_win(input logic w, input int start, input int len, input logic [1:0] dm);
        for (int k = 0; k < len; k++) begin
            ex_rd[start+k]   = !w;
            ex_wr[start+k]   = w;
            ex_beat[start+k] = 3'(2 * k);
            ex_dm[start+k]   = w ? dm : 2'b00;
        end
    endtask

    task automatic drive(input int c);
        if (c < NCYC) begin
            cmd_valid = sc_v[c]; cmd_is_write = sc_w[c]; cfg_cl = sc_cl[c];
            cfg_al = sc_al[c]; cfg_bl8 = sc_b[c]; cmd_dm = sc_dm[c];
        end else begin
            cmd_valid = 0; cmd_is_write = 0; cfg_cl = 0; cfg_al = 0; cfg_bl8 = 0; cmd_dm = 0;
        end
    endtask

    // script entry c is sampled on edge c; trace c is observed after edge c
    task automatic run_and_check(input string req);
        @(negedge clk);
        drive(0);
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            chk(req,  "rd_en",       c, int'(rd_en),       int'(ex_rd[c]));
            chk(req,  "wr_en",       c, int'(wr_en),       int'(ex_wr[c]));
            chk("R7", "both_en",     c, int'(rd_en & wr_en), 0);
            chk("R5", "beat_idx",    c, int'(beat_idx),    int'(ex_beat[c]));
            chk("R6", "wr_dm",       c, int'(wr_dm),       int'(ex_dm[c]));
            chk("R9", "overlap_err", c, int'(overlap_err), int'(ex_err[c]));
            drive(c + 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R10: outputs held low during reset
        repeat (3) @(negedge clk);
        chk("R10", "rd_en in reset", 0, int'(rd_en), 0);
        chk("R10", "wr_en in reset", 0, int'(wr_en), 0);
        chk("R10", "beat in reset",  0, int'(beat_idx), 0);
        chk("R10", "err in reset",   0, int'(overlap_err), 0);
        rst = 1'b0;

        // Table walk: R1 reads, R2 writes, R4 both burst lengths, R3 clamped entries 6 and 7
        for (int i = 0; i < 8; i++) begin
            clear_all();
            put_cmd(0, 1'b1, VECS[i].wr, VECS[i].cl, VECS[i].al, VECS[i].bl8, VECS[i].dm);
            add_win(VECS[i].wr, int'(VECS[i].lead), int'(VECS[i].len), VECS[i].dm);
            run_and_check(i >= 6 ? "R3" : (VECS[i].wr ? "R2" : "R1"));
        end

        // R8: two reads two clocks apart form one seamless 4-clock window
        clear_all();
        put_cmd(0, 1'b1, 1'b0, 3'd3, 3'd0, 1'b0, 2'b00);
        put_cmd(2, 1'b1, 1'b0, 3'd3, 3'd0, 1'b0, 2'b00);
        add_win(1'b0, 3, 2, 2'b00);
        add_win(1'b0, 5, 2, 2'b00);
        run_and_check("R8");

        // R9: write one clock too early after a read collides and is dropped
        clear_all();
        put_cmd(0, 1'b1, 1'b0, 3'd3, 3'd0, 1'b0, 2'b00);
        put_cmd(2, 1'b1, 1'b1, 3'd3, 3'd0, 1'b0, 2'b11);
        add_win(1'b0, 3, 2, 2'b00);
        ex_err[2] = 1'b1;
        run_and_check("R9");

        // R9 boundary: write one clock later abuts the read and is accepted
        clear_all();
        put_cmd(0, 1'b1, 1'b0, 3'd3, 3'd0, 1'b0, 2'b00);
        put_cmd(3, 1'b1, 1'b1, 3'd3, 3'd0, 1'b0, 2'b11);
        add_win(1'b0, 3, 2, 2'b00);
        add_win(1'b1, 5, 2, 2'b11);
        run_and_check("R9");

        // R9: same settings on consecutive edges with 8 beats overlap
        clear_all();
        put_cmd(0, 1'b1, 1'b0, 3'd3, 3'd0, 1'b1, 2'b00);
        put_cmd(1, 1'b1, 1'b0, 3'd3, 3'd0, 1'b1, 2'b00);
        add_win(1'b0, 3, 4, 2'b00);
        ex_err[1] = 1'b1;
        run_and_check("R9");

        // R8: three in flight, completion order differs from issue order
        clear_all();
        put_cmd(0, 1'b1, 1'b0, 3'd6, 3'd4, 1'b0, 2'b00);
        put_cmd(1, 1'b1, 1'b1, 3'd3, 3'd0, 1'b0, 2'b10);
        put_cmd(2, 1'b1, 1'b0, 3'd3, 3'd1, 1'b1, 2'b00);
        add_win(1'b0, 10, 2, 2'b00);
        add_win(1'b1, 3, 2, 2'b10);
        add_win(1'b0, 6, 4, 2'b00);
        run_and_check("R8");

        // R11: settings changed on the next edges without a command leave the window as issued
        clear_all();
        put_cmd(0, 1'b1, 1'b0, 3'd3, 3'd0, 1'b1, 2'b00);
        put_cmd(1, 1'b0, 1'b1, 3'd6, 3'd4, 1'b0, 2'b11);
        put_cmd(2, 1'b0, 1'b1, 3'd6, 3'd4, 1'b0, 2'b11);
        add_win(1'b0, 3, 4, 2'b00);
        run_and_check("R11");

        // R10: reset while a command is pending discards it
        clear_all();
        put_cmd(0, 1'b1, 1'b0, 3'd6, 3'd4, 1'b0, 2'b00);
        @(negedge clk);
        drive(0);
        @(negedge clk);
        drive(1);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10", "rd_en at reset", 0, int'(rd_en), 0);
        rst = 1'b0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            chk("R10", "rd_en after flush", c, int'(rd_en), 0);
            chk("R10", "wr_en after flush", c, int'(wr_en), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule